// File: doc/BRIEF.md
# Display Interrupt Status Controller

This block gathers the interrupt sources of a display adapter behind one level-sensitive request line. Software reaches it through a small register bus that carries two 32-bit registers. One register holds the enables. The other holds the latched status, and software clears its bits by writing ones to them. Hardware events set status bits through a pulse input vector. A built-in divider sets the vertical-blank bit at a fixed period, standing in for a frame-rate tick.

Software drives the vertical-blank ticker through the enable register. A write that sets the vertical-blank enable bit latches a vertical-blank event at once and starts the period count again from zero. A write that clears that bit stops the ticker. A strap input picks one of two device variants, and each variant allows a different set of status bits to be cleared by software.

Top module: `disp_irq_ctrl`

## Requirements
- R1: After reset both registers read zero, `irq` is low and the vertical-blank ticker is stopped. With no write, the status register stays zero for any number of cycles.
- R2: A read of byte offset 0x40 returns the enable register and a read of 0x44 returns the status register. `rdata` carries the value in the cycle after `rd_en` and is zero in every other cycle.
- R3: The address is compared in full, so every other offset, 0x41 included, is unmapped. A read of an unmapped offset returns zero, and a write to one changes neither register.
- R4: `irq` is high exactly when the bitwise AND of status and enable is nonzero.
- R5: A write to 0x44 clears each status bit where `wdata` AND the clear mask has a 1. All other bits are left unchanged, so writing zero has no effect.
- R6: When `variant_sel` is 1 the clear mask is 0x000F040F. When it is 0 the clear mask is 0xFC080EFF.
- R7: A write to 0x40 with bit 0 (vertical blank) set stores the data and sets status bit 0 in the same clock edge.
- R8: Once started by the write in R7, the ticker sets status bit 0 every PERIOD cycles. The first tick comes PERIOD cycles after the enabling write, and a new enabling write restarts the count.
- R9: A write to 0x40 with bit 0 clear stops the ticker, so status bit 0 is no longer set by it.
- R10: A status bit that is set by an event in the same cycle as a software clear of that bit stays set.
- R11: Each 1 in `evt_set` sets the matching status bit in the following edge. Bit 1 is vertical line match and bit 2 is vertical sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| evt_set | input | 32 | Event pulses, one per status bit |
| variant_sel | input | 1 | Device-variant strap that selects the clear mask |
| irq | output | 1 | Level interrupt request |

## Verification
A wrong status or enable bit becomes visible in two places. `irq` shows it in the same cycle as the bad value, once a matching enable is set, and the next status read shows it one cycle later. A wrong clear mask leaves a bit set, or clears one that should stay, and this shows on the first read after a clear write. A fault in the ticker shifts the cycle at which bit 0 reappears after it has been cleared. Timing each reappearance against the enabling write therefore catches a period that is off by one, a restart that does not reset the count, or a stop that does not stop the ticker, each within one period.

// File: rtl/disp_irq_pkg.sv
package disp_irq_pkg;

    localparam int unsigned REG_W      = 32;
    localparam int unsigned BIT_VBLANK = 0;
    localparam int unsigned BIT_VLINE  = 1;
    localparam int unsigned BIT_VSYNC  = 2;

    localparam logic [REG_W-1:0] CLR_MASK_V1 = 32'h000F_040F;
    localparam logic [REG_W-1:0] CLR_MASK_V0 = 32'hFC08_0EFF;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_EN   = 2'd1,
        SEL_ST   = 2'd2
    } reg_sel_t;

    typedef struct packed {
        logic [REG_W-1:0] en;
        logic [REG_W-1:0] st;
    } irq_regs_t;

endpackage

// File: rtl/disp_addr_dec.sv
module disp_addr_dec
    import disp_irq_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned EN_OFS = 'h40,
    parameter int unsigned ST_OFS = 'h44
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);
    localparam logic [ADDR_W-1:0] EN_A = ADDR_W'(EN_OFS);
    localparam logic [ADDR_W-1:0] ST_A = ADDR_W'(ST_OFS);

    always_comb begin
        if (addr == EN_A) begin
            sel = SEL_EN;
        end else if (addr == ST_A) begin
            sel = SEL_ST;
        end else begin
            sel = SEL_NONE;
        end
    end
endmodule

// File: rtl/disp_vblank_timer.sv
module disp_vblank_timer #(
    parameter int unsigned PERIOD = 2083333
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic stop,
    output logic tick
);
    localparam int unsigned CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             run;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    assign tick = tmr_q.run && (tmr_q.cnt == LAST);

    always_comb begin
        tmr_d = tmr_q;
        if (restart) begin
            tmr_d.run = 1'b1;
            tmr_d.cnt = '0;
        end else if (stop) begin
            tmr_d.run = 1'b0;
            tmr_d.cnt = '0;
        end else if (tmr_q.run) begin
            if (tmr_q.cnt == LAST) begin
                tmr_d.cnt = '0;
            end else begin
                tmr_d.cnt = tmr_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end
endmodule

// File: rtl/disp_irq_regs.sv
module disp_irq_regs
    import disp_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  reg_sel_t         sel,
    input  logic [REG_W-1:0] wdata,
    input  logic [REG_W-1:0] clr_mask,
    input  logic [REG_W-1:0] set_vec,
    output logic [REG_W-1:0] en_q,
    output logic [REG_W-1:0] st_q
);
    irq_regs_t regs_d, regs_q;
    logic [REG_W-1:0] clr_vec;

    always_comb begin
        regs_d  = regs_q;
        clr_vec = '0;
        if (wr_en && sel == SEL_EN) begin
            regs_d.en = wdata;
        end
        if (wr_en && sel == SEL_ST) begin
            clr_vec = wdata & clr_mask;
        end
        // set wins over a clear of the same bit
        regs_d.st = (regs_q.st & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign en_q = regs_q.en;
    assign st_q = regs_q.st;
endmodule

// File: rtl/disp_rd_port.sv
module disp_rd_port
    import disp_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  reg_sel_t         sel,
    input  logic [REG_W-1:0] en,
    input  logic [REG_W-1:0] st,
    output logic [REG_W-1:0] rdata
);
    logic [REG_W-1:0] rd_d, rd_q;

    always_comb begin
        rd_d = '0;
        if (rd_en) begin
            unique case (sel)
                SEL_EN:  rd_d = en;
                SEL_ST:  rd_d = st;
                default: rd_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rdata = rd_q;
endmodule

// File: rtl/disp_irq_ctrl.sv
module disp_irq_ctrl
    import disp_irq_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned EN_OFS = 'h40,
    parameter int unsigned ST_OFS = 'h44,
    parameter int unsigned PERIOD = 2083333
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic [31:0]       evt_set,
    input  logic              variant_sel,
    output logic              irq
);
    reg_sel_t         sel;
    logic [REG_W-1:0] en_q, st_q, clr_mask, set_vec;
    logic             vb_tick, vb_restart, vb_stop, en_wr;

    disp_addr_dec #(.ADDR_W(ADDR_W), .EN_OFS(EN_OFS), .ST_OFS(ST_OFS)) u_dec (
        .addr (addr),
        .sel  (sel)
    );

    assign en_wr      = wr_en && (sel == SEL_EN);
    assign vb_restart = en_wr && wdata[BIT_VBLANK];
    assign vb_stop    = en_wr && !wdata[BIT_VBLANK];

    disp_vblank_timer #(.PERIOD(PERIOD)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (vb_restart),
        .stop    (vb_stop),
        .tick    (vb_tick)
    );

    assign clr_mask = variant_sel ? CLR_MASK_V1 : CLR_MASK_V0;

    always_comb begin
        set_vec = evt_set;
        set_vec[BIT_VBLANK] = evt_set[BIT_VBLANK] | vb_tick | vb_restart;
    end

    disp_irq_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .sel      (sel),
        .wdata    (wdata),
        .clr_mask (clr_mask),
        .set_vec  (set_vec),
        .en_q     (en_q),
        .st_q     (st_q)
    );

    disp_rd_port u_rd (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_en (rd_en),
        .sel   (sel),
        .en    (en_q),
        .st    (st_q),
        .rdata (rdata)
    );

    assign irq = |(st_q & en_q);
endmodule

// File: rtl/disp_irq_ctrl_chk.sv
module disp_irq_ctrl_chk #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned EN_OFS = 'h40,
    parameter int unsigned ST_OFS = 'h44
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic [31:0]       rdata,
    input logic [31:0]       evt_set,
    input logic              variant_sel,
    input logic              irq,
    input logic [31:0]       en_q,
    input logic [31:0]       st_q,
    input logic              tick
);
    logic        is_en, is_st;
    logic [31:0] mask;
    assign is_en = (addr == ADDR_W'(EN_OFS));
    assign is_st = (addr == ADDR_W'(ST_OFS));
    assign mask  = variant_sel ? 32'h000F_040F : 32'hFC08_0EFF;

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!irq && rdata == 32'h0));

    assert_unmapped_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !is_en && !is_st) |=> (rdata == 32'h0));

    assert_irq_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (en_q != 32'h0 && st_q != 32'h0));

    assert_clear_takes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && is_st && evt_set == 32'h0 && !tick)
            |=> ((st_q & $past(wdata & mask)) == 32'h0));

    assert_vblank_on_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && is_en && wdata[0]) |=> (st_q[0] && en_q[0]));

    assert_stop_no_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && is_en && !wdata[0]) |=> !tick);

    assert_event_sets_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_set != 32'h0) |=> ((st_q & $past(evt_set)) == $past(evt_set)));
endmodule

bind disp_irq_ctrl disp_irq_ctrl_chk #(.ADDR_W(ADDR_W), .EN_OFS(EN_OFS), .ST_OFS(ST_OFS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .addr        (addr),
    .wdata       (wdata),
    .rdata       (rdata),
    .evt_set     (evt_set),
    .variant_sel (variant_sel),
    .irq         (irq),
    .en_q        (en_q),
    .st_q        (st_q),
    .tick        (vb_tick)
);

// File: tb/disp_irq_ctrl_test.sv
`timescale 1ns/1ps
module disp_irq_ctrl_test;
    localparam int unsigned P = 16;
    localparam logic [31:0] M1 = 32'h000F_040F;
    localparam logic [31:0] M0 = 32'hFC08_0EFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0, evt_set = '0;
    logic [31:0] rdata;
    logic        variant_sel = 1'b1;
    logic        irq;

    int n_chk = 0, n_fail = 0, cyc = 0, last = 0;
    logic [31:0] exp_st, exp_en, rv;

    disp_irq_ctrl #(.ADDR_W(8), .PERIOD(P)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .evt_set(evt_set),
        .variant_sel(variant_sel), .irq(irq)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
        last = cyc;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
        last = cyc;
    endtask

    task automatic pulse(input logic [31:0] v);
        evt_set = v;
        @(negedge clk);
        evt_set = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] cur_mask();
        return variant_sel ? M1 : M0;
    endfunction

    initial begin
        #(8 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        finish_run();
    end

    initial begin
        int e0;
        int first;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, ticker idle
        check("R1 irq", {31'h0, irq}, 32'h0);
        rd(8'h40, rv); check("R1 enable", rv, 32'h0);
        idle(3 * P);
        rd(8'h44, rv); check("R1 status idle", rv, 32'h0);
        check("R2 rdata idle zero", rdata, 32'h0);

        // load known state, bit 0 of enable kept clear
        exp_en = 32'hFFFF_FFFE; wr(8'h40, exp_en);
        exp_st = 32'hA5A5_5A5A; pulse(exp_st);

        // R2 / R3: read sweep over every offset
        for (int a = 0; a < 256; a++) begin
            rd(8'(a), rv);
            if (a == 'h40)      check("R2 read enable", rv, exp_en);
            else if (a == 'h44) check("R2 read status", rv, exp_st);
            else                check("R3 unmapped read", rv, 32'h0);
        end
        // R3: writes to unmapped offsets
        for (int a = 0; a < 256; a++) begin
            if (a != 'h40 && a != 'h44) wr(8'(a), 32'hFFFF_FFFF);
        end
        rd(8'h40, rv); check("R3 enable untouched", rv, exp_en);
        rd(8'h44, rv); check("R3 status untouched", rv, exp_st);

        // R4: irq for a single enable bit each
        for (int b = 1; b < 32; b++) begin
            wr(8'h40, 32'h1 << b);
            check("R4 irq single enable", {31'h0, irq}, {31'h0, exp_st[b]});
        end
        wr(8'h40, 32'h0);
        check("R4 irq no enable", {31'h0, irq}, 32'h0);

        // R5 / R6: clear sweep for both variants
        for (int v = 0; v < 2; v++) begin
            variant_sel = v[0];
            for (int b = 0; b < 32; b++) begin
                pulse(32'hFFFF_FFFF);
                wr(8'h44, 32'h1 << b);
                rd(8'h44, rv);
                check("R6 masked clear", rv, ~(cur_mask() & (32'h1 << b)));
            end
            wr(8'h44, 32'h0);
            rd(8'h44, rv);
            check("R5 zero write no effect", rv, ~(cur_mask() & 32'h8000_0000) & ~(cur_mask() & 32'h8000_0000));
            wr(8'h44, 32'hFFFF_FFFF);
            rd(8'h44, rv);
            check("R6 full clear", rv, ~cur_mask());
        end
        exp_st = ~M1;

        // R11: single event bits
        pulse(32'h4); exp_st |= 32'h4;
        rd(8'h44, rv); check("R11 vsync event", rv, exp_st);
        pulse(32'h2); exp_st |= 32'h2;
        rd(8'h44, rv); check("R11 vline event", rv, exp_st);

        // R10: set beats clear in the same cycle
        wr_en = 1'b1; addr = 8'h44; wdata = 32'h3; evt_set = 32'h1;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0; evt_set = '0;
        exp_st = (exp_st & ~32'h3) | 32'h1;
        rd(8'h44, rv); check("R10 set wins", rv, exp_st);
        wr(8'h44, 32'h1); exp_st &= ~32'h1;
        rd(8'h44, rv); check("R5 bit0 cleared", rv, exp_st);

        // R7: enabling vblank latches bit 0 at once
        wr(8'h40, 32'h1); e0 = last;
        rd(8'h44, rv); check("R7 vblank on enable", rv, exp_st | 32'h1);
        check("R4 irq vblank", {31'h0, irq}, 32'h1);

        // R8: first tick P cycles after enable, read shows it one later
        wr(8'h44, 32'h1);
        first = -1;
        for (int i = 0; i < 3 * P && first < 0; i++) begin
            rd(8'h44, rv);
            if (rv[0]) first = last;
        end
        check("R8 first tick", 32'(first - e0), 32'(P + 1));
        wr(8'h44, 32'h1);
        first = -1;
        for (int i = 0; i < 3 * P && first < 0; i++) begin
            rd(8'h44, rv);
            if (rv[0]) first = last;
        end
        check("R8 second tick", 32'(first - e0), 32'(2 * P + 1));

        // R8: restart mid-period
        idle(5);
        wr(8'h40, 32'h1); e0 = last;
        wr(8'h44, 32'h1);
        first = -1;
        for (int i = 0; i < 3 * P && first < 0; i++) begin
            rd(8'h44, rv);
            if (rv[0]) first = last;
        end
        check("R8 restart tick", 32'(first - e0), 32'(P + 1));

        // R9: stop
        wr(8'h40, 32'h0);
        wr(8'h44, 32'h1);
        idle(3 * P);
        rd(8'h44, rv); check("R9 stopped", {31'h0, rv[0]}, 32'h0);
        check("R9 irq low", {31'h0, irq}, 32'h0);

        // R1: reset while ticker runs
        wr(8'h40, 32'h1);
        idle(4);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        check("R1 irq after reset", {31'h0, irq}, 32'h0);
        idle(3 * P);
        rd(8'h44, rv); check("R1 status after reset", rv, 32'h0);
        rd(8'h40, rv); check("R1 enable after reset", rv, 32'h0);

        finish_run();
    end
endmodule